// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block sequences a switched-capacitor converter from sleep through a current-limited wake-up into normal operation. Each power switch of the converter is split into several parallel segments whose gates are driven separately. Fewer enabled segments give a higher switch resistance, and a higher switch resistance limits the inrush current that flows into the discharged capacitors.

While the power request is low, the block keeps everything off. When the request rises, it enables the oscillator, the digital control and the converter stages, and it enables one segment in every switch. After that it adds one segment at a time. A segment is added only after a programmable number of consecutive switching periods in which the shunt comparators report the input current below the low threshold. While the current is above the high threshold, the segment count is frozen.

When every segment is on, the block enters normal mode. In normal mode it reports regulation once all output-range comparators agree. Dropping the power request returns the block to sleep from any state.

Top module: `soft_start_seq`

## Requirements
- R1: After reset, and for as long as pwr_req is low, osc_en, ctrl_en, stage_en, seg_mask and reg_ok are all 0, whatever the other inputs do.
- R2: On the cycle after a clock edge that samples pwr_req high in sleep, osc_en, ctrl_en and stage_en are 1 and each switch has exactly one segment on. Switch s owns seg_mask bits [s*8+7 : s*8], and the segments of a switch fill upward from that switch's bit 0.
- R3: During soft-start a switching period counts as quiet when sw_tick is 1, cur_below_lo is 1 and cur_above_hi is 0. On the cycle after the edge that samples the dwell_periods-th consecutive quiet period, every switch gains one segment. A sw_tick with cur_below_lo at 0 restarts the count.
- R4: A sw_tick with cur_above_hi at 1 leaves the segment count unchanged and restarts the quiet count. This holds even when cur_below_lo is also 1.
- R5: A dwell_periods value of 0 behaves as 1, so each quiet period adds a segment.
- R6: Once the eighth segment is on, the block is in normal mode. seg_mask then stays all ones whatever the current comparators report.
- R7: reg_ok is 1 on the cycle after an edge at which the block is in normal mode, pwr_req is 1 and every out_in_range bit is 1. Otherwise reg_ok is 0. In particular, reg_ok stays 0 during soft-start even when the outputs are in range.
- R8: On the cycle after an edge that samples pwr_req low, from soft-start or from normal mode, all enables, seg_mask and reg_ok are 0.
- R9: All switches always carry the same segment pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power-on request |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| cur_below_lo | input | 1 | Input current below low threshold |
| cur_above_hi | input | 1 | Input current above high threshold |
| dwell_periods | input | 8 | Quiet periods required per added segment |
| out_in_range | input | 2 | Per-output in-range flags |
| osc_en | output | 1 | Oscillator enable |
| ctrl_en | output | 1 | Digital control enable |
| stage_en | output | 1 | Converter stage enable |
| seg_mask | output | 32 | Segment gate enables, 8 per switch, 4 switches |
| reg_ok | output | 1 | All outputs in regulation |

## Verification
Every output is due exactly one cycle after the clock edge that samples the stimulus that causes it. This holds for the enables, for the segment added on the final quiet tick, for the status flag and for the release to sleep. The driver computes each expected output from the requirement rules at the moment it applies the inputs, and tags that expectation with the following cycle number. The monitor compares each tagged expectation only two nanoseconds after that cycle's rising edge. A change that arrives one cycle early or one cycle late therefore shows up as a mismatch.

// File: rtl/ss_pkg.sv
package ss_pkg;

    localparam int SS_DWELL_W = 8;

    typedef enum logic [1:0] {
        SS_SLEEP  = 2'd0,
        SS_SOFT   = 2'd1,
        SS_NORMAL = 2'd2
    } ss_mode_e;

    typedef struct packed {
        logic osc;
        logic ctrl;
        logic stage;
    } ss_enables_t;

    // A zero dwell setting is treated as a single period.
    function automatic logic [SS_DWELL_W-1:0] eff_limit(input logic [SS_DWELL_W-1:0] d);
        return (d == '0) ? SS_DWELL_W'(1) : d;
    endfunction

endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer
    import ss_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm,
    input  logic                  tick,
    input  logic                  cur_lo,
    input  logic                  cur_hi,
    input  logic [SS_DWELL_W-1:0] dwell,
    output logic                  step
);

    logic [SS_DWELL_W-1:0] quiet;
    logic [SS_DWELL_W:0]   quiet_nxt;
    logic                  quiet_tick;
    logic                  at_limit;

    assign quiet_tick = tick & cur_lo & ~cur_hi;
    assign quiet_nxt  = {1'b0, quiet} + (SS_DWELL_W+1)'(1);
    assign at_limit   = quiet_nxt >= {1'b0, eff_limit(dwell)};
    assign step       = arm & quiet_tick & at_limit;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            quiet <= '0;
        end else if (tick) begin
            if (!quiet_tick || at_limit) begin
                quiet <= '0;
            end else begin
                quiet <= quiet_nxt[SS_DWELL_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int INIT_SEG = 1,
    parameter int CW       = $clog2(NUM_SEG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_req,
    input  logic          step,
    input  logic          all_ok,
    output ss_mode_e      mode,
    output logic [CW-1:0] seg_cnt,
    output logic          reg_ok
);

    localparam logic [CW-1:0] FULL  = CW'(NUM_SEG);
    localparam logic [CW-1:0] START = CW'((INIT_SEG > NUM_SEG) ? NUM_SEG : INIT_SEG);

    logic [CW-1:0] cnt_inc;
    assign cnt_inc = seg_cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= SS_SLEEP;
            seg_cnt <= '0;
            reg_ok  <= 1'b0;
        end else begin
            reg_ok <= pwr_req && (mode == SS_NORMAL) && all_ok;
            if (!pwr_req) begin
                mode    <= SS_SLEEP;
                seg_cnt <= '0;
            end else begin
                case (mode)
                    SS_SLEEP: begin
                        seg_cnt <= START;
                        mode    <= (START == FULL) ? SS_NORMAL : SS_SOFT;
                    end
                    SS_SOFT: begin
                        if (step) begin
                            seg_cnt <= cnt_inc;
                            if (cnt_inc == FULL) begin
                                mode <= SS_NORMAL;
                            end
                        end
                    end
                    SS_NORMAL: seg_cnt <= FULL;
                    default: begin
                        mode    <= SS_SLEEP;
                        seg_cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ss_seg_mask.sv
module ss_seg_mask #(
    parameter int NUM_SW  = 4,
    parameter int NUM_SEG = 8,
    parameter int CW      = $clog2(NUM_SEG + 1)
) (
    input  logic [CW-1:0]             cnt,
    output logic [NUM_SW*NUM_SEG-1:0] mask
);

    for (genvar sw = 0; sw < NUM_SW; sw++) begin : g_sw
        for (genvar b = 0; b < NUM_SEG; b++) begin : g_seg
            localparam logic [CW-1:0] IDX = CW'(b);
            assign mask[sw*NUM_SEG + b] = IDX < cnt;
        end
    end

endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
    import ss_pkg::*;
#(
    parameter int NUM_SW   = 4,
    parameter int NUM_SEG  = 8,
    parameter int INIT_SEG = 1,
    parameter int NUM_OUT  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pwr_req,
    input  logic                      sw_tick,
    input  logic                      cur_below_lo,
    input  logic                      cur_above_hi,
    input  logic [SS_DWELL_W-1:0]     dwell_periods,
    input  logic [NUM_OUT-1:0]        out_in_range,
    output logic                      osc_en,
    output logic                      ctrl_en,
    output logic                      stage_en,
    output logic [NUM_SW*NUM_SEG-1:0] seg_mask,
    output logic                      reg_ok
);

    localparam int CW = $clog2(NUM_SEG + 1);

    ss_mode_e      mode;
    logic [CW-1:0] seg_cnt;
    logic          step;
    ss_enables_t   en;

    ss_dwell_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (mode == SS_SOFT),
        .tick   (sw_tick),
        .cur_lo (cur_below_lo),
        .cur_hi (cur_above_hi),
        .dwell  (dwell_periods),
        .step   (step)
    );

    ss_seq_fsm #(
        .NUM_SEG  (NUM_SEG),
        .INIT_SEG (INIT_SEG),
        .CW       (CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pwr_req (pwr_req),
        .step    (step),
        .all_ok  (&out_in_range),
        .mode    (mode),
        .seg_cnt (seg_cnt),
        .reg_ok  (reg_ok)
    );

    ss_seg_mask #(
        .NUM_SW  (NUM_SW),
        .NUM_SEG (NUM_SEG),
        .CW      (CW)
    ) u_mask (
        .cnt  (seg_cnt),
        .mask (seg_mask)
    );

    always_comb begin
        en       = '0;
        en.osc   = mode != SS_SLEEP;
        en.ctrl  = mode != SS_SLEEP;
        en.stage = mode != SS_SLEEP;
    end

    assign osc_en   = en.osc;
    assign ctrl_en  = en.ctrl;
    assign stage_en = en.stage;

endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int NUM_SW  = 4,
    parameter int NUM_SEG = 8,
    parameter int NUM_OUT = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      pwr_req,
    input logic                      sw_tick,
    input logic                      cur_below_lo,
    input logic                      cur_above_hi,
    input logic [NUM_OUT-1:0]        out_in_range,
    input logic                      osc_en,
    input logic                      ctrl_en,
    input logic                      stage_en,
    input logic [NUM_SW*NUM_SEG-1:0] seg_mask,
    input logic                      reg_ok
);

    logic [NUM_SEG-1:0] sw0;
    logic               same_all;
    int                 cnt0;

    assign sw0  = seg_mask[NUM_SEG-1:0];
    assign cnt0 = $countones(sw0);

    always_comb begin
        same_all = 1'b1;
        for (int s = 1; s < NUM_SW; s++) begin
            if (seg_mask[s*NUM_SEG +: NUM_SEG] != sw0) same_all = 1'b0;
        end
    end

    assert_sleep_dark_R1: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (seg_mask == '0 && !reg_ok && !ctrl_en && !stage_en));

    assert_enables_tied_R2: assert property (@(posedge clk) disable iff (rst)
        (osc_en == ctrl_en) && (ctrl_en == stage_en));

    assert_fill_order_R2: assert property (@(posedge clk) disable iff (rst)
        ((sw0 & (sw0 + NUM_SEG'(1))) == '0));

    assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
        (stage_en && $past(stage_en)) |-> (cnt0 >= $past(cnt0) && cnt0 <= $past(cnt0) + 1));

    assert_step_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (stage_en && $past(stage_en) && cnt0 == $past(cnt0) + 1)
            |-> $past(sw_tick && cur_below_lo && !cur_above_hi));

    assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(stage_en && sw_tick && cur_above_hi) && stage_en) |-> cnt0 == $past(cnt0));

    assert_status_full_R7: assert property (@(posedge clk) disable iff (rst)
        reg_ok |-> ((&seg_mask) && $past(&out_in_range) && $past(pwr_req)));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!pwr_req) |-> (!osc_en && seg_mask == '0 && !reg_ok));

    assert_same_mask_R9: assert property (@(posedge clk) disable iff (rst)
        same_all);

endmodule

bind soft_start_seq ss_checker #(
    .NUM_SW  (NUM_SW),
    .NUM_SEG (NUM_SEG),
    .NUM_OUT (NUM_OUT)
) u_chk (.*);

// File: tb/tb_soft_start_seq.sv
`timescale 1ns/1ps
module tb_soft_start_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_req = 1'b0;
    logic        sw_tick = 1'b0;
    logic        cur_below_lo = 1'b0;
    logic        cur_above_hi = 1'b0;
    logic [7:0]  dwell_periods = 8'd1;
    logic [1:0]  out_in_range = 2'b00;
    logic        osc_en, ctrl_en, stage_en, reg_ok;
    logic [31:0] seg_mask;

    always #5 clk = ~clk;

    soft_start_seq dut (
        .clk           (clk),
        .rst           (rst),
        .pwr_req       (pwr_req),
        .sw_tick       (sw_tick),
        .cur_below_lo  (cur_below_lo),
        .cur_above_hi  (cur_above_hi),
        .dwell_periods (dwell_periods),
        .out_in_range  (out_in_range),
        .osc_en        (osc_en),
        .ctrl_en       (ctrl_en),
        .stage_en      (stage_en),
        .seg_mask      (seg_mask),
        .reg_ok        (reg_ok)
    );

    typedef struct {
        int          stamp;
        bit          en;
        logic [31:0] mask;
        bit          rok;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Requirement-level model state: 0 sleep, 1 soft-start, 2 normal
    int m_mode = 0;
    int m_cnt  = 0;
    int m_q    = 0;
    bit m_rok  = 1'b0;

    always @(posedge clk) cyc++;

    function automatic logic [31:0] mask_of(int n);
        logic [31:0] m = '0;
        for (int s = 0; s < 4; s++)
            for (int b = 0; b < n; b++) m[s*8 + b] = 1'b1;
        return m;
    endfunction

    task automatic step(bit pwr, bit tick, bit lo, bit hi, bit [1:0] ok, int dw, string tag);
        exp_t it;
        int   lim;
        int   old_mode;
        @(negedge clk);
        pwr_req = pwr; sw_tick = tick; cur_below_lo = lo; cur_above_hi = hi;
        out_in_range = ok; dwell_periods = 8'(dw);
        old_mode = m_mode;
        lim = (dw == 0) ? 1 : dw;
        m_rok = pwr && (old_mode == 2) && (ok == 2'b11);
        if (!pwr) begin
            m_mode = 0; m_cnt = 0; m_q = 0;
        end else if (old_mode == 0) begin
            m_mode = 1; m_cnt = 1; m_q = 0;
        end else if (old_mode == 1 && tick) begin
            if (hi || !lo) m_q = 0;
            else if (m_q + 1 >= lim) begin
                m_q = 0; m_cnt++;
                if (m_cnt == 8) m_mode = 2;
            end else m_q++;
        end
        it.stamp = cyc + 1;
        it.en    = (m_mode != 0);
        it.mask  = mask_of(m_cnt);
        it.rok   = m_rok;
        it.tag   = tag;
        q.push_back(it);
    endtask

    always @(posedge clk) begin : monitor
        exp_t it;
        #2;
        if (q.size() > 0 && q[0].stamp == cyc) begin
            it = q.pop_front();
            n_cmp++;
            if ({osc_en, ctrl_en, stage_en} !== {3{it.en}} || seg_mask !== it.mask || reg_ok !== it.rok) begin
                n_bad++;
                $display("FAIL %s cyc %0d: actual en=%b%b%b mask=%h ok=%b expected en=%b mask=%h ok=%b",
                         it.tag, cyc, osc_en, ctrl_en, stage_en, seg_mask, reg_ok,
                         it.en, it.mask, it.rok);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state and sleep ignores other inputs
        step(0, 0, 0, 0, 2'b00, 1, "R1");
        step(0, 1, 1, 0, 2'b11, 1, "R1");
        step(0, 1, 0, 1, 2'b11, 0, "R1");
        step(0, 0, 1, 0, 2'b11, 1, "R1");

        // R2: wake with one segment per switch
        step(1, 0, 0, 0, 2'b00, 3, "R2");
        step(1, 0, 1, 0, 2'b00, 3, "R2");

        // R3: three quiet ticks per segment, with idle cycles between
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 0, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        // R3: a non-quiet tick restarts the count
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 0, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");
        step(1, 1, 1, 0, 2'b00, 3, "R3");

        // R4: high current holds the count even with the low flag set
        step(1, 1, 1, 0, 2'b00, 3, "R4");
        step(1, 1, 1, 0, 2'b00, 3, "R4");
        step(1, 1, 1, 1, 2'b00, 3, "R4");
        step(1, 1, 1, 1, 2'b00, 1, "R4");
        step(1, 1, 0, 1, 2'b00, 1, "R4");
        step(1, 1, 1, 0, 2'b11, 3, "R7");
        step(1, 1, 1, 0, 2'b11, 3, "R7");
        step(1, 1, 1, 0, 2'b11, 3, "R4");

        // R5: zero dwell adds one segment per quiet tick
        step(1, 1, 1, 0, 2'b00, 0, "R5");
        step(1, 1, 1, 0, 2'b00, 0, "R5");
        step(1, 1, 1, 0, 2'b00, 0, "R9");
        step(1, 1, 1, 0, 2'b00, 0, "R6");

        // R6: normal mode ignores the current flags
        step(1, 1, 0, 1, 2'b00, 0, "R6");
        step(1, 1, 1, 1, 2'b00, 1, "R6");
        step(1, 0, 0, 0, 2'b00, 1, "R6");

        // R7: status follows the range flags in normal mode
        step(1, 0, 0, 0, 2'b11, 1, "R7");
        step(1, 0, 0, 0, 2'b11, 1, "R7");
        step(1, 0, 0, 0, 2'b01, 1, "R7");
        step(1, 0, 0, 0, 2'b10, 1, "R7");
        step(1, 0, 0, 0, 2'b11, 1, "R7");

        // R8: release from normal, then from mid soft-start
        step(0, 0, 0, 0, 2'b11, 1, "R8");
        step(0, 0, 0, 0, 2'b11, 1, "R8");
        step(1, 0, 0, 0, 2'b00, 2, "R8");
        step(1, 1, 1, 0, 2'b00, 2, "R9");
        step(1, 1, 1, 0, 2'b00, 2, "R9");
        step(0, 1, 1, 0, 2'b00, 2, "R8");
        step(1, 0, 0, 0, 2'b00, 2, "R2");
        step(1, 1, 1, 0, 2'b00, 2, "R3");

        repeat (4) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule